// File: doc/BRIEF.md
# Double-Buffered Channel Attenuation Bank

This block holds the volume settings of a multichannel audio converter. Each output channel has a two-stage 8-bit attenuation register. The first stage is a pending latch and the second is the live latch that drives the datapath. The level runs in 0.5 dB steps, and the all-ones code means no attenuation. Control words come in on a single-cycle write strobe with a 7-bit address and a 9-bit data field. The upper data bit is a commit flag and is never stored.

A write with the commit flag clear only places a value in one channel's pending latch, and the audible level does not change. A write with the commit flag set stores its value and then copies the pending latch of every channel into its live latch on the same edge, so all channels change level together. A master register loads one value into every channel at once. The live levels leave the block as one flat parallel bus.

Top module: `atten_bank`

## Requirements
- R1: A synchronous active-low reset sets every pending and live latch to 8'hFF (0 dB), both at start-up and in the middle of a run.
- R2: A write is taken on a clock edge where `wr_en` is 1. `data[7:0]` is the level and `data[8]` is the commit flag. The live outputs reflect the write on that same edge and can be seen in the following cycle.
- R3: Address k, for k from 0 to 5, selects channel k. Even k is a left channel and odd k is a right channel. Channel k's live level is on `act_lvl[8k+7:8k]`.
- R4: A channel write with `data[8]`=0 stores the level in that channel's pending latch only, and no live output changes.
- R5: A channel write with `data[8]`=1 copies every channel's pending level into its live latch at once.
- R6: In a committing channel write, the addressed channel's live latch takes the level written in that same write, not the older pending value.
- R7: A write to address 8 with `data[8]`=1 sets every pending latch and every live latch to the written level.
- R8: A write to address 8 with `data[8]`=0 sets every pending latch to the written level and leaves all live outputs unchanged.
- R9: A write to address 6, 7 or 9..127 changes no pending or live latch, whatever the value of its commit flag.
- R10: While `wr_en` is 0, `addr` and `data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 7 | Register address |
| data | input | 9 | Bit 8 is the commit flag and bits 7:0 are the level |
| act_lvl | output | 48 | Live levels, channel k on bits 8k+7:8k |

## Verification
Every result is due exactly one clock edge after the strobe, because the pending and live latches both update on the edge that samples the write. The bench drives each write at a falling edge, lets one rising edge take it, and compares all six live levels at the next falling edge against a model that steps its pending and live arrays in the same order. Pending contents cannot be seen directly. They are exposed by the next committing write, so a stray change to a pending latch shows up one write later.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int unsigned ATTEN_LVL_W   = 8;
    localparam int unsigned ATTEN_ADDR_W  = 7;
    localparam int unsigned ATTEN_N_CH    = 6;
    localparam int unsigned ATTEN_MASTER  = 8;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_CHAN   = 2'd1,
        HIT_MASTER = 2'd2
    } hit_kind_e;
endpackage

// File: rtl/atten_wr_decode.sv
module atten_wr_decode #(
    parameter int unsigned N_CH        = atten_pkg::ATTEN_N_CH,
    parameter int unsigned ADDR_W      = atten_pkg::ATTEN_ADDR_W,
    parameter int unsigned LVL_W       = atten_pkg::ATTEN_LVL_W,
    parameter int unsigned MASTER_ADDR = atten_pkg::ATTEN_MASTER,
    localparam int unsigned DATA_W     = LVL_W + 1
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output logic [N_CH-1:0]      load_sel,
    output logic [LVL_W-1:0]     load_lvl,
    output logic                 xfer_all,
    output atten_pkg::hit_kind_e hit_kind
);
    logic [N_CH-1:0] chan_hit;

    // one comparator per channel address
    for (genvar i = 0; i < N_CH; i++) begin : g_hit
        assign chan_hit[i] = wr_en && (addr == ADDR_W'(i));
    end

    always_comb begin
        hit_kind = atten_pkg::HIT_NONE;
        if (|chan_hit) begin
            hit_kind = atten_pkg::HIT_CHAN;
        end else if (wr_en && (addr == ADDR_W'(MASTER_ADDR))) begin
            hit_kind = atten_pkg::HIT_MASTER;
        end
    end

    always_comb begin
        load_lvl = data[LVL_W-1:0];
        unique case (hit_kind)
            atten_pkg::HIT_CHAN:   load_sel = chan_hit;
            atten_pkg::HIT_MASTER: load_sel = '1;
            default:               load_sel = '0;
        endcase
        // an unmapped write never commits
        xfer_all = (hit_kind != atten_pkg::HIT_NONE) && data[LVL_W];
    end
endmodule

// File: rtl/atten_chan_stage.sv
module atten_chan_stage #(
    parameter int unsigned LVL_W = atten_pkg::ATTEN_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [LVL_W-1:0] load_lvl,
    input  logic             xfer_en,
    output logic [LVL_W-1:0] act_lvl
);
    typedef struct packed {
        logic [LVL_W-1:0] pend;
        logic [LVL_W-1:0] act;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.pend = load_lvl;
        end
        // transfer the freshly loaded value when both happen together
        if (xfer_en) begin
            st_d.act = st_d.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_lvl = st_q.act;
endmodule

// File: rtl/atten_bank.sv
module atten_bank #(
    parameter int unsigned N_CH        = atten_pkg::ATTEN_N_CH,
    parameter int unsigned ADDR_W      = atten_pkg::ATTEN_ADDR_W,
    parameter int unsigned LVL_W       = atten_pkg::ATTEN_LVL_W,
    parameter int unsigned MASTER_ADDR = atten_pkg::ATTEN_MASTER,
    localparam int unsigned DATA_W     = LVL_W + 1,
    localparam int unsigned BUS_W      = N_CH * LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [BUS_W-1:0]  act_lvl
);
    logic [N_CH-1:0]      load_sel;
    logic [LVL_W-1:0]     load_lvl;
    logic                 xfer_all;
    atten_pkg::hit_kind_e hit_kind;

    atten_wr_decode #(
        .N_CH(N_CH), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .MASTER_ADDR(MASTER_ADDR)
    ) u_dec (
        .wr_en(wr_en), .addr(addr), .data(data),
        .load_sel(load_sel), .load_lvl(load_lvl),
        .xfer_all(xfer_all), .hit_kind(hit_kind)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        atten_chan_stage #(.LVL_W(LVL_W)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .load_en(load_sel[k]), .load_lvl(load_lvl),
            .xfer_en(xfer_all),
            .act_lvl(act_lvl[k*LVL_W +: LVL_W])
        );
    end
endmodule

// File: rtl/atten_bank_chk.sv
module atten_bank_chk #(
    parameter int unsigned N_CH        = 6,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned LVL_W       = 8,
    parameter int unsigned MASTER_ADDR = 8,
    localparam int unsigned DATA_W     = LVL_W + 1,
    localparam int unsigned BUS_W      = N_CH * LVL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data,
    input logic [BUS_W-1:0]  act_lvl
);
    logic unmapped;
    logic to_master;
    assign to_master = (addr == ADDR_W'(MASTER_ADDR));
    assign unmapped  = (int'(addr) >= int'(N_CH)) && !to_master;

    p_reset_ff_r1: assert property (@(posedge clk)
        !rst_n |=> (act_lvl == {BUS_W{1'b1}}));

    p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !data[LVL_W] && !to_master && !unmapped) |=> $stable(act_lvl));

    p_master_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && to_master && data[LVL_W]) |=>
            (act_lvl == {N_CH{$past(data[LVL_W-1:0])}}));

    p_master_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && to_master && !data[LVL_W]) |=> $stable(act_lvl));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unmapped) |=> $stable(act_lvl));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(act_lvl));

    for (genvar k = 0; k < N_CH; k++) begin : g_new
        p_fresh_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && data[LVL_W] && (addr == ADDR_W'(k))) |=>
                (act_lvl[k*LVL_W +: LVL_W] == $past(data[LVL_W-1:0])));
    end
endmodule

bind atten_bank atten_bank_chk #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .MASTER_ADDR(MASTER_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .data(data), .act_lvl(act_lvl)
);

// File: tb/atten_bank_tb.sv
module atten_bank_tb;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [8:0]  data = '0;
    logic [47:0] act_lvl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_pend [NCH];
    logic [7:0] m_act  [NCH];

    always #10 clk = ~clk;

    atten_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .data(data), .act_lvl(act_lvl)
    );

    function automatic logic [47:0] exp_bus();
        logic [47:0] b;
        for (int k = 0; k < NCH; k++) b[k*8 +: 8] = m_act[k];
        return b;
    endfunction

    task automatic chk(input string tag);
        logic [47:0] e;
        e = exp_bus();
        checks++;
        if (act_lvl !== e) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act_lvl, e);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NCH; k++) begin
            m_pend[k] = 8'hFF;
            m_act[k]  = 8'hFF;
        end
    endtask

    // R2: drive at falling edge, take on rising edge, compare at next falling edge
    task automatic wr(input logic [6:0] a, input logic [8:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = a; data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (int'(a) < NCH) begin
            m_pend[a] = d[7:0];
            if (d[8]) for (int k = 0; k < NCH; k++) m_act[k] = m_pend[k];
        end else if (a == 7'd8) begin
            for (int k = 0; k < NCH; k++) m_pend[k] = d[7:0];
            if (d[8]) for (int k = 0; k < NCH; k++) m_act[k] = m_pend[k];
        end
        chk(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset levels");

        // R4: stage distinct values, outputs must hold
        for (int k = 0; k < NCH; k++) wr(7'(k), {1'b0, 8'(8'h10 + k*8'h11)}, "R4 stage only");
        // R5/R6/R3: commit via channel 3 with a fresh value
        wr(7'd3, {1'b1, 8'h5A}, "R6 fresh value commit");
        // R3: one channel at a time reaches its own slice
        for (int k = 0; k < NCH; k++) wr(7'(k), {1'b1, 8'(8'h80 ^ k)}, "R3 channel slice");

        // R10: strobe low with busy inputs
        @(negedge clk);
        addr = 7'd8; data = 9'h1_00;
        repeat (4) @(negedge clk);
        chk("R10 idle strobe");

        // R8 then R5 exposes pending loaded by master
        wr(7'd8, {1'b0, 8'h33}, "R8 master stage");
        wr(7'd5, {1'b1, 8'h44}, "R8 pending exposed by commit R5");
        // R7 master commit
        wr(7'd8, {1'b1, 8'h21}, "R7 master commit");

        // R9 with near-exhaustive address sweep, pending revealed by later commits
        for (int a = 0; a < 128; a++) begin
            logic [8:0] d;
            d = {1'(a[0] ^ a[2]), 8'(a * 37 + 11)};
            wr(7'(a), d,
               (a < NCH) ? (d[8] ? "R5 sweep commit" : "R4 sweep stage") :
               (a == 8)  ? (d[8] ? "R7 sweep" : "R8 sweep") : "R9 unmapped");
            if (a >= NCH && a != 8) wr(7'(a % NCH), {1'b1, 8'(a)}, "R9 pending intact R5");
        end

        // level sweep across all codes
        for (int v = 0; v < 256; v++)
            wr(7'(v % NCH), {1'((v % 7) == 6), 8'(v)}, "R5 level sweep");

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R1 mid-run reset");
        wr(7'd0, {1'b1, 8'h01}, "R1 pending reset to FF R5");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule